// File: doc/BRIEF.md
# Multi-channel windowed pulse counter bank

This block counts rising edges on a set of independent, asynchronous pulse inputs (twenty by default) and reports how many edges each channel saw during a fixed counting window. Every flop runs on a single system clock. Each input passes through a two-stage synchronizer, and a third stage then delays it so that edges can be detected. A per-channel enable qualifies each edge before it reaches that channel's counter.

An internal down-counting timer divides time into windows. When the timer's long "count" phase ends, one strobe cycle copies every live count into a per-channel shadow register, together with a sticky wrap flag. In that same clock edge the live counters restart. An edge that lands on the strobe cycle is not lost: it becomes the first count of the new window. A one-cycle `snap_valid` pulse marks each capture. A small indexed read port gives a serial slave or other reader the captured values with one cycle of latency.

Top module: `pulse_tally_bank`

## Requirements
- R1: A pulse that stays high for at least two clock cycles and then low for at least two cycles is counted exactly once, however long it stays high.
- R2: While a channel's `chan_en` bit is low, its edges do not change its count.
- R3: The first capture takes place on the (HIGH_LEN+1)-th rising clock edge after reset is released, and later captures follow every PERIOD edges. `snap_valid` is high only during the cycle that follows a capture edge.
- R4: At a capture, the shadow register takes the number of edges counted since the previous capture, and the live counter restarts from zero.
- R5: An edge whose count falls on the capture edge itself goes into the new window. The new window therefore starts at 1, and the captured value excludes that edge.
- R6: An edge counted one clock before the capture edge belongs to the closing window.
- R7: Counters wrap modulo 2^CNT_W. A wrap sets a sticky flag, which is captured with the count (`rd_ovf`) and cleared at each capture.
- R8: `rd_data`/`rd_ovf` show the shadow value of the channel at `rd_idx`, one clock after the index is presented.
- R9: An index of NUM_CH or above reads as count 0 with the flag clear.
- R10: A synchronous reset clears counters, shadows, read outputs, `snap_valid` and the window timer.
- R11: Channels count independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pulse_in | input | NUM_CH | Asynchronous pulse inputs, one bit per channel |
| chan_en | input | NUM_CH | Per-channel count enable |
| rd_idx | input | IDX_W | Channel index for the read port |
| rd_data | output | CNT_W | Captured count of the selected channel |
| rd_ovf | output | 1 | Captured wrap flag of the selected channel |
| snap_valid | output | 1 | One-cycle pulse after each capture |

## Verification
Some properties are checked on every cycle by the embedded assertions. The strobe is one cycle wide and lands on the first gap cycle of the timer. A qualified edge outside the strobe adds exactly one. The strobe cycle moves the live count into the shadow and restarts the counter at 0 or 1. An edge never qualifies on two consecutive cycles, and out-of-range reads return zero. Other behaviour is shown only by the bench scenarios. These cover the exact capture cycle measured from reset release, and the window an edge lands in when it arrives right at or just before the capture. They also cover wrap and the clearing of the flag across windows, channel independence, and the reset of captured data.

// File: rtl/pulse_tally_pkg.sv
package pulse_tally_pkg;
   localparam int DEF_NUM_CH   = 20;
   localparam int DEF_CNT_W    = 18;
   localparam int DEF_PERIOD   = 70_490_000;
   localparam int DEF_HIGH_LEN = 66_500_000;

   typedef enum logic {
      PH_GAP   = 1'b0,
      PH_COUNT = 1'b1
   } win_phase_t;
endpackage

// File: rtl/pt_edge_sync.sv
module pt_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_in,
   output logic rise
);
   if (STAGES < 2) begin : g_bad
      $error("pt_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] chain_q;

   always_ff @(posedge clk) begin
      if (rst) chain_q[0] <= 1'b0;
      else     chain_q[0] <= async_in;
   end

   for (genvar i = 1; i <= STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) chain_q[i] <= 1'b0;
         else     chain_q[i] <= chain_q[i-1];
      end
   end

   assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

   // R1
   rise_single_chk: assert property (@(posedge clk) disable iff (rst)
      rise |=> !rise);
endmodule

// File: rtl/pt_window_timer.sv
module pt_window_timer
   import pulse_tally_pkg::*;
#(
   parameter int PERIOD   = DEF_PERIOD,
   parameter int HIGH_LEN = DEF_HIGH_LEN
) (
   input  logic clk,
   input  logic rst,
   output logic snap_stb
);
   localparam int TW      = (PERIOD > 1) ? $clog2(PERIOD) : 1;
   localparam int LOW_LEN = PERIOD - HIGH_LEN;

   if (HIGH_LEN < 1 || LOW_LEN < 1) begin : g_bad
      $error("pt_window_timer: need 1 <= HIGH_LEN < PERIOD");
   end

   logic [TW-1:0] tcnt_q;
   logic          stb_q;
   win_phase_t    phase;

   assign phase = (tcnt_q >= TW'(LOW_LEN)) ? PH_COUNT : PH_GAP;

   always_ff @(posedge clk) begin
      if (rst) begin
         tcnt_q <= TW'(PERIOD - 1);
         stb_q  <= 1'b0;
      end else begin
         tcnt_q <= (tcnt_q == '0) ? TW'(PERIOD - 1) : tcnt_q - 1'b1;
         stb_q  <= (tcnt_q == TW'(LOW_LEN));
      end
   end

   assign snap_stb = stb_q;

   // R3
   stb_width_chk: assert property (@(posedge clk) disable iff (rst)
      snap_stb |=> !snap_stb);
   // R3
   stb_phase_chk: assert property (@(posedge clk) disable iff (rst)
      snap_stb |-> (phase == PH_GAP) && ($past(phase) == PH_COUNT));
endmodule

// File: rtl/pt_channel.sv
module pt_channel #(
   parameter int CNT_W = 18
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             rise,
   input  logic             en,
   input  logic             snap_stb,
   output logic [CNT_W-1:0] shadow_cnt,
   output logic             shadow_ovf
);
   if (CNT_W < 2) begin : g_bad
      $error("pt_channel: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             ovf_q;
   logic             hit;

   assign hit = rise & en;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q      <= '0;
         ovf_q      <= 1'b0;
         shadow_cnt <= '0;
         shadow_ovf <= 1'b0;
      end else if (snap_stb) begin
         shadow_cnt <= cnt_q;
         shadow_ovf <= ovf_q;
         cnt_q      <= {{(CNT_W-1){1'b0}}, hit};
         ovf_q      <= 1'b0;
      end else if (hit) begin
         cnt_q <= cnt_q + 1'b1;
         if (&cnt_q) ovf_q <= 1'b1;
      end
   end

   // R1
   count_step_chk: assert property (@(posedge clk) disable iff (rst)
      (!snap_stb && hit) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
   // R2
   hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (!snap_stb && !hit) |=> $stable(cnt_q));
   // R4
   capture_copy_chk: assert property (@(posedge clk) disable iff (rst)
      snap_stb |=> (shadow_cnt == $past(cnt_q)) && (shadow_ovf == $past(ovf_q)));
   // R5
   restart_chk: assert property (@(posedge clk) disable iff (rst)
      snap_stb |=> (cnt_q == CNT_W'($past(hit))) && !ovf_q);
endmodule

// File: rtl/pulse_tally_bank.sv
module pulse_tally_bank
   import pulse_tally_pkg::*;
#(
   parameter int NUM_CH      = DEF_NUM_CH,
   parameter int CNT_W       = DEF_CNT_W,
   parameter int PERIOD      = DEF_PERIOD,
   parameter int HIGH_LEN    = DEF_HIGH_LEN,
   parameter int SYNC_STAGES = 2,
   parameter int IDX_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NUM_CH-1:0] pulse_in,
   input  logic [NUM_CH-1:0] chan_en,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [CNT_W-1:0]  rd_data,
   output logic              rd_ovf,
   output logic              snap_valid
);
   if (NUM_CH < 1 || (1 << IDX_W) < NUM_CH) begin : g_bad
      $error("pulse_tally_bank: IDX_W too small for NUM_CH");
   end

   logic             snap_stb;
   logic [CNT_W-1:0] sh_cnt [NUM_CH];
   logic             sh_ovf [NUM_CH];

   pt_window_timer #(.PERIOD(PERIOD), .HIGH_LEN(HIGH_LEN)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .snap_stb (snap_stb)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic rise;

      pt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk      (clk),
         .rst      (rst),
         .async_in (pulse_in[c]),
         .rise     (rise)
      );

      pt_channel #(.CNT_W(CNT_W)) u_cnt (
         .clk        (clk),
         .rst        (rst),
         .rise       (rise),
         .en         (chan_en[c]),
         .snap_stb   (snap_stb),
         .shadow_cnt (sh_cnt[c]),
         .shadow_ovf (sh_ovf[c])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_data    <= '0;
         rd_ovf     <= 1'b0;
         snap_valid <= 1'b0;
      end else begin
         snap_valid <= snap_stb;
         if (32'(rd_idx) < NUM_CH) begin
            rd_data <= sh_cnt[rd_idx];
            rd_ovf  <= sh_ovf[rd_idx];
         end else begin
            rd_data <= '0;
            rd_ovf  <= 1'b0;
         end
      end
   end

   // R9
   range_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (32'(rd_idx) >= NUM_CH) |=> (rd_data == '0) && !rd_ovf);
   // R3
   valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      snap_valid |=> !snap_valid);
endmodule

// File: tb/pulse_tally_bank_bench.sv
module pulse_tally_bank_bench;
   localparam int NCH  = 20;
   localparam int CW   = 6;
   localparam int PER  = 600;
   localparam int HIGH = 540;
   localparam int E1   = HIGH + 1;

   localparam int ROWS = 6;
   localparam int T_CH  [ROWS] = '{0, 1, 5, 7, 19, 12};
   localparam int T_N   [ROWS] = '{3, 0, 7, 12, 20, 4};
   localparam int T_HI  [ROWS] = '{2, 2, 2, 2, 3, 10};
   localparam int T_EN  [ROWS] = '{1, 1, 1, 0, 1, 1};
   localparam int T_EXP [ROWS] = '{3, 0, 7, 0, 20, 4};

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic [NCH-1:0]  pin = '0;
   logic [NCH-1:0]  en  = '1;
   logic [4:0]      idx = '0;
   logic [CW-1:0]   rdata;
   logic            rovf;
   logic            sval;
   int              cyc = 0;
   int              n_chk = 0;
   int              n_fail = 0;
   bit              done = 1'b0;

   always #2 clk = ~clk;

   always @(posedge clk) begin
      if (rst) cyc <= 0;
      else     cyc <= cyc + 1;
   end

   pulse_tally_bank #(.NUM_CH(NCH), .CNT_W(CW), .PERIOD(PER), .HIGH_LEN(HIGH)) u_pulse_tally_bank (
      .clk (clk), .rst (rst), .pulse_in (pin), .chan_en (en),
      .rd_idx (idx), .rd_data (rdata), .rd_ovf (rovf), .snap_valid (sval)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   task automatic pulses(input int ch, input int n, input int hi);
      for (int k = 0; k < n; k++) begin
         pin[ch] = 1'b1;
         repeat (hi) @(negedge clk);
         pin[ch] = 1'b0;
         repeat (2) @(negedge clk);
      end
   endtask

   task automatic read_ch(input int ch, input int exp_cnt, input int exp_ovf, input string tag);
      idx = 5'(ch);
      @(negedge clk);
      check(int'(rdata) == exp_cnt, tag, int'(rdata), exp_cnt);
      check(int'(rovf) == exp_ovf, {tag, " flag"}, int'(rovf), exp_ovf);
   endtask

   task automatic check_valid_around(input int e);
      wait_cyc(e - 1);
      check(sval == 1'b0, "R3 snap_valid before capture", int'(sval), 0);
      wait_cyc(e);
      check(sval == 1'b1, "R3 snap_valid after capture edge", int'(sval), 1);
      wait_cyc(e + 1);
      check(sval == 1'b0, "R3 snap_valid one cycle wide", int'(sval), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      check(rdata == '0, "R10 reset rd_data", int'(rdata), 0);
      check(sval == 1'b0, "R10 reset snap_valid", int'(sval), 0);
      rst = 1'b0;

      // Window 1: table of stimulus rows (R1, R2, R11)
      for (int r = 0; r < ROWS; r++) en[T_CH[r]] = T_EN[r][0];
      for (int r = 0; r < ROWS; r++) pulses(T_CH[r], T_N[r], T_HI[r]);
      check_valid_around(E1);
      for (int r = 0; r < ROWS; r++)
         read_ch(T_CH[r], T_EXP[r], 0, "R4 R1 R2 R11 window1 count");
      read_ch(25, 0, 0, "R9 index 25");
      read_ch(31, 0, 0, "R9 index 31");
      // R8: index change shows on rd_data after one clock
      read_ch(19, 20, 0, "R8 read ch19");
      read_ch(0, 3, 0, "R8 read ch0");

      // Window 2: wrap on ch3 (R7); earlier counts cleared (R4)
      en = '1;
      pulses(3, (1 << CW) + 2, 2);
      check_valid_around(E1 + PER);
      read_ch(3, 2, 1, "R7 wrap count");
      read_ch(0, 0, 0, "R4 cleared after capture");
      read_ch(19, 0, 0, "R4 ch19 cleared");

      // Window 3: coincident and just-early edges (R5, R6)
      pulses(4, 2, 2);
      wait_cyc(E1 + 2*PER - 4);
      pin[6] = 1'b1;
      wait_cyc(E1 + 2*PER - 3);
      pin[4] = 1'b1;
      wait_cyc(E1 + 2*PER);
      check(sval == 1'b1, "R3 third capture", int'(sval), 1);
      pin[4] = 1'b0;
      pin[6] = 1'b0;
      read_ch(4, 2, 0, "R5 coincident edge excluded");
      read_ch(6, 1, 0, "R6 early edge in old window");
      read_ch(3, 0, 0, "R7 flag cleared next window");
      wait_cyc(E1 + 3*PER + 1);
      read_ch(4, 1, 0, "R5 coincident edge in new window");
      read_ch(6, 0, 0, "R6 not recounted");

      // Reset in mid-window (R10)
      pulses(2, 3, 2);
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      check(sval == 1'b0, "R10 snap_valid after reset", int'(sval), 0);
      read_ch(4, 0, 0, "R10 shadow cleared");
      check_valid_around(E1);
      read_ch(2, 0, 0, "R10 counter cleared");

      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule